// File: doc/BRIEF.md
# Processor Reset-Exit Sequencer

This block governs how a processor core leaves reset. While the active-low reset input is low it holds the core quiet. The pipeline flush and cache invalidate strobes stay high. Bus cycles and instruction execution stay off. A fixed set of architectural starting values is presented to the register file. The control-word value keeps paging off, protection off (real mode) and the cache disabled.

When reset is released, the sequencer samples a 2-bit clock-scaling code and a self-test request. It then counts a start-up delay picked by the code. If self-test was requested, it adds a further long window and latches a pass/fail input at the end of that window. The failure bit is placed in the accumulator start value.

It then raises a fetch request at the top-of-memory entry address. The request stays up until the memory side acknowledges it. After the acknowledge the core runs. Pulling reset low at any time returns the sequencer to its held state and restarts every count.

Top module: `cpu_reset_seq`

## Requirements
- R1: While `rstN` is low, `pipeFlush` and `cacheInval` are 1 and `fetchReq`, `busEnable` and `execEnable` are 0.
- R2: The start values are fixed at all times: `flagsInit` = 00000002h. `ctl0Init` = 60000010h, where bit 31 (paging) = 0, bit 0 (protection) = 0 and bit 30 (cache disable) = 1. `ctl4Init` = 0, `intTblBase` = 0 and `intTblLimit` = 3FFh.
- R3: The segment start values are fixed: `segSel` = 0000h, `segBase` = 0 and `segLimit` = FFFFh for all data segments. `codeSel` = F000h, `codeBase` = FFFF0000h and `ipInit` = 0000FFF0h.
- R4: `dataInit` is {16'h0000, 8'h04, deviceId}.
- R5: Let E0 be the first rising clock edge with `rstN` high. Without self-test, `fetchReq` first goes high right after edge E0+N. N is 150, 183, 216 or 250 for `clkScale` codes 0, 1, 2 or 3.
- R6: `clkScale` and `selfTestReq` are sampled only at edge E0. Changes after E0 do not alter the timing.
- R7: With self-test requested, exactly ST_CYCLES further edges are inserted before `fetchReq` rises. The default is 2^20.
- R8: `selfTestPass` is sampled at the last edge of the self-test window. `accInit` is 00000000h on pass and 00000001h on fail. It is 00000000h when no self-test ran or while the window is open.
- R9: While `fetchReq` is high, `fetchAddr` is FFFFFFF0h, the code base plus the entry offset. `fetchReq` stays high until an edge samples `fetchAck` high.
- R10: After that edge, `fetchReq` is 0 and `execEnable` and `busEnable` are 1 until the next reset. `pipeFlush` is 0.
- R11: Driving `rstN` low at any point returns the outputs to the R1 state at once. The next release restarts the full count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| clkScale | input | 2 | Clock-scaling code, selects start-up delay |
| selfTestReq | input | 1 | Self-test request, sampled at release |
| selfTestPass | input | 1 | Self-test outcome, sampled at end of window |
| deviceId | input | 8 | Device identifier for the data start value |
| fetchAck | input | 1 | Acknowledge of the first fetch |
| fetchReq | output | 1 | First fetch request |
| fetchAddr | output | 32 | Physical address of the first fetch |
| busEnable | output | 1 | Bus activity allowed |
| execEnable | output | 1 | Instruction execution allowed |
| pipeFlush | output | 1 | Pipeline flush strobe |
| cacheInval | output | 1 | Cache invalidate strobe |
| accInit | output | 32 | Accumulator start value |
| dataInit | output | 32 | Data register start value |
| flagsInit | output | 32 | Flags start value |
| ipInit | output | 32 | Instruction pointer start value |
| codeSel | output | 16 | Code segment selector |
| codeBase | output | 32 | Code segment base |
| segSel | output | 16 | Data segment selector |
| segBase | output | 32 | Data segment base |
| segLimit | output | 32 | Segment limit |
| ctl0Init | output | 32 | Control word 0 start value |
| ctl4Init | output | 32 | Control word 4 start value |
| intTblBase | output | 32 | Interrupt table base |
| intTblLimit | output | 16 | Interrupt table limit |

## Verification
The assertions check the following on every cycle:
- the quiet outputs during reset;
- the fetch request holding until acknowledged, and always carrying the entry address;
- execution starting only after an acknowledged fetch;
- the delay counter never being decremented past zero;
- the accumulator value changing only at the capture edge.

The exact edge on which the fetch request rises, for each scaling code with and without self-test, can only be shown by the bench's timed scenarios. The same holds for the insensitivity to inputs changed after release, the pass/fail result, and the restart after a reset pulled mid-count.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_DELAY,
    ST_TEST,
    ST_FETCH,
    ST_RUN
  } seqState_t;

  typedef struct packed {
    logic loadDelay;
    logic loadTest;
    logic countDown;
    logic capture;
  } seqStrobe_t;

  localparam logic [31:0] FLAGS_RST   = 32'h0000_0002;
  localparam logic [31:0] CTL0_RST    = 32'h6000_0010;
  localparam logic [31:0] CTL4_RST    = 32'h0000_0000;
  localparam logic [31:0] IP_RST      = 32'h0000_FFF0;
  localparam logic [15:0] CODE_SEL    = 16'hF000;
  localparam logic [31:0] CODE_BASE   = 32'hFFFF_0000;
  localparam logic [15:0] DSEG_SEL    = 16'h0000;
  localparam logic [31:0] DSEG_BASE   = 32'h0000_0000;
  localparam logic [31:0] SEG_LIMIT   = 32'h0000_FFFF;
  localparam logic [31:0] ITBL_BASE   = 32'h0000_0000;
  localparam logic [15:0] ITBL_LIMIT  = 16'h03FF;
  localparam logic [7:0]  DATA_REV    = 8'h04;

endpackage

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import cpu_rst_pkg::*;
#(
  parameter int DLY0      = 150,
  parameter int DLY1      = 183,
  parameter int DLY2      = 216,
  parameter int DLY3      = 250,
  parameter int ST_CYCLES = 1 << 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  strb,
  input  logic [1:0]  clkScale,
  input  logic        selfTestReq,
  input  logic        selfTestPass,
  input  logic [7:0]  deviceId,
  output logic        cntZero,
  output logic        testArmed,
  output logic [31:0] accInit,
  output logic [31:0] dataInit,
  output logic [31:0] fetchAddr
);

  localparam int MAX_A   = (DLY0 > DLY1) ? DLY0 : DLY1;
  localparam int MAX_B   = (DLY2 > DLY3) ? DLY2 : DLY3;
  localparam int MAX_D   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CNT = (MAX_D > ST_CYCLES) ? MAX_D : ST_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt;
  logic             stFail;

  function automatic logic [CNT_W-1:0] pickDelay(input logic [1:0] code);
    logic [CNT_W-1:0] v;
    case (code)
      2'd0:    v = CNT_W'(DLY0 - 1);
      2'd1:    v = CNT_W'(DLY1 - 1);
      2'd2:    v = CNT_W'(DLY2 - 1);
      default: v = CNT_W'(DLY3 - 1);
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      testArmed <= 1'b0;
      stFail    <= 1'b0;
    end else begin
      if (strb.loadDelay) begin
        cnt       <= pickDelay(clkScale);
        testArmed <= selfTestReq;
      end else if (strb.loadTest) begin
        cnt <= CNT_W'(ST_CYCLES - 1);
      end else if (strb.countDown) begin
        cnt <= cnt - 1'b1;
      end
      if (strb.capture) begin
        stFail <= ~selfTestPass;
      end
    end
  end

  assign cntZero   = (cnt == '0);
  assign accInit   = {31'b0, stFail};
  assign dataInit  = {16'h0000, DATA_REV, deviceId};
  assign fetchAddr = CODE_BASE + IP_RST;

  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.countDown |-> (cnt != '0));

  assert_acc_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(accInit));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import cpu_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntZero,
  input  logic       testArmed,
  input  logic       fetchAck,
  output seqStrobe_t strb,
  output logic       fetchReq,
  output logic       busEnable,
  output logic       execEnable,
  output logic       pipeFlush,
  output logic       cacheInval
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_HOLD: begin
        strb.loadDelay = 1'b1;
        nextState      = ST_DELAY;
      end
      ST_DELAY: begin
        if (cntZero) begin
          if (testArmed) begin
            strb.loadTest = 1'b1;
            nextState     = ST_TEST;
          end else begin
            nextState = ST_FETCH;
          end
        end else begin
          strb.countDown = 1'b1;
        end
      end
      ST_TEST: begin
        if (cntZero) begin
          strb.capture = 1'b1;
          nextState    = ST_FETCH;
        end else begin
          strb.countDown = 1'b1;
        end
      end
      ST_FETCH: begin
        if (fetchAck) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  assign pipeFlush  = (state == ST_HOLD);
  assign cacheInval = (state == ST_HOLD);
  assign fetchReq   = (state == ST_FETCH);
  assign busEnable  = (state == ST_FETCH) || (state == ST_RUN);
  assign execEnable = (state == ST_RUN);

  always @(posedge clk) begin
    if (rstN === 1'b0) begin
      assert_hold_quiet_R1: assert (pipeFlush && cacheInval && !fetchReq && !busEnable && !execEnable);
    end
  end

  assert_fetch_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck) |=> fetchReq);

  assert_run_after_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(execEnable) |-> $past(fetchReq && fetchAck));

  assert_run_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    execEnable |=> (execEnable && !fetchReq));

endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import cpu_rst_pkg::*;
#(
  parameter int DLY0      = 150,
  parameter int DLY1      = 183,
  parameter int DLY2      = 216,
  parameter int DLY3      = 250,
  parameter int ST_CYCLES = 1 << 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  clkScale,
  input  logic        selfTestReq,
  input  logic        selfTestPass,
  input  logic [7:0]  deviceId,
  input  logic        fetchAck,
  output logic        fetchReq,
  output logic [31:0] fetchAddr,
  output logic        busEnable,
  output logic        execEnable,
  output logic        pipeFlush,
  output logic        cacheInval,
  output logic [31:0] accInit,
  output logic [31:0] dataInit,
  output logic [31:0] flagsInit,
  output logic [31:0] ipInit,
  output logic [15:0] codeSel,
  output logic [31:0] codeBase,
  output logic [15:0] segSel,
  output logic [31:0] segBase,
  output logic [31:0] segLimit,
  output logic [31:0] ctl0Init,
  output logic [31:0] ctl4Init,
  output logic [31:0] intTblBase,
  output logic [15:0] intTblLimit
);

  seqStrobe_t strb;
  logic       cntZero;
  logic       testArmed;

  rst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntZero    (cntZero),
    .testArmed  (testArmed),
    .fetchAck   (fetchAck),
    .strb       (strb),
    .fetchReq   (fetchReq),
    .busEnable  (busEnable),
    .execEnable (execEnable),
    .pipeFlush  (pipeFlush),
    .cacheInval (cacheInval)
  );

  rst_seq_datapath #(
    .DLY0      (DLY0),
    .DLY1      (DLY1),
    .DLY2      (DLY2),
    .DLY3      (DLY3),
    .ST_CYCLES (ST_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .clkScale     (clkScale),
    .selfTestReq  (selfTestReq),
    .selfTestPass (selfTestPass),
    .deviceId     (deviceId),
    .cntZero      (cntZero),
    .testArmed    (testArmed),
    .accInit      (accInit),
    .dataInit     (dataInit),
    .fetchAddr    (fetchAddr)
  );

  assign flagsInit   = FLAGS_RST;
  assign ipInit      = IP_RST;
  assign codeSel     = CODE_SEL;
  assign codeBase    = CODE_BASE;
  assign segSel      = DSEG_SEL;
  assign segBase     = DSEG_BASE;
  assign segLimit    = SEG_LIMIT;
  assign ctl0Init    = CTL0_RST;
  assign ctl4Init    = CTL4_RST;
  assign intTblBase  = ITBL_BASE;
  assign intTblLimit = ITBL_LIMIT;

  assert_vector_R9: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (fetchAddr == 32'hFFFF_FFF0));

endmodule

// File: tb/sim_cpu_reset_seq.sv
module sim_cpu_reset_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ST_CYC     = 64;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  clkScale = 2'd0;
  logic        selfTestReq = 1'b0;
  logic        selfTestPass = 1'b0;
  logic [7:0]  deviceId = 8'h00;
  logic        fetchAck = 1'b0;
  logic        fetchReq, busEnable, execEnable, pipeFlush, cacheInval;
  logic [31:0] fetchAddr, accInit, dataInit, flagsInit, ipInit, codeBase;
  logic [31:0] segBase, segLimit, ctl0Init, ctl4Init, intTblBase;
  logic [15:0] codeSel, segSel, intTblLimit;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cpu_reset_seq #(.ST_CYCLES(ST_CYC)) u0 (
    .clk(clk), .rstN(rstN), .clkScale(clkScale), .selfTestReq(selfTestReq),
    .selfTestPass(selfTestPass), .deviceId(deviceId), .fetchAck(fetchAck),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .busEnable(busEnable),
    .execEnable(execEnable), .pipeFlush(pipeFlush), .cacheInval(cacheInval),
    .accInit(accInit), .dataInit(dataInit), .flagsInit(flagsInit), .ipInit(ipInit),
    .codeSel(codeSel), .codeBase(codeBase), .segSel(segSel), .segBase(segBase),
    .segLimit(segLimit), .ctl0Init(ctl0Init), .ctl4Init(ctl4Init),
    .intTblBase(intTblBase), .intTblLimit(intTblLimit)
  );

  function automatic int expDelay(input logic [1:0] code);
    case (code)
      2'd0:    return 150;
      2'd1:    return 183;
      2'd2:    return 216;
      default: return 250;
    endcase
  endfunction

  function automatic logic [31:0] expAcc(input bit req, input bit pass);
    return (req && !pass) ? 32'h1 : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkConstants(input logic [7:0] dev);
    chk("R2 flags", flagsInit, 32'h0000_0002);
    chk("R2 ctl0", ctl0Init, 32'h6000_0010);
    chk("R2 ctl4", ctl4Init, 32'h0);
    chk("R2 itbl", {intTblBase[15:0], intTblLimit}, {16'h0, 16'h03FF});
    chk("R3 code", {codeSel, 16'h0}, {16'hF000, 16'h0});
    chk("R3 codeBase", codeBase, 32'hFFFF_0000);
    chk("R3 ip", ipInit, 32'h0000_FFF0);
    chk("R3 seg", {segSel, segLimit[15:0]}, {16'h0000, 16'hFFFF});
    chk("R3 segBase", segBase, 32'h0);
    chk("R4 data", dataInit, {16'h0, 8'h04, dev});
  endtask

  task automatic checkHeld(input string tag);
    chk(tag, {27'b0, pipeFlush, cacheInval, fetchReq, busEnable, execEnable},
        {27'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic runTrial(input logic [1:0] scale, input bit req, input bit pass,
                          input int ackDly, input int abortAt, input logic [7:0] dev);
    int total;
    total = expDelay(scale) + (req ? ST_CYC : 0);
    @(negedge clk);
    rstN = 1'b0;
    fetchAck = 1'b0;
    deviceId = dev;
    repeat (2) @(negedge clk);
    checkHeld("R1 held");
    chk("R8 acc in reset", accInit, 32'h0);
    checkConstants(dev);
    clkScale = scale;
    selfTestReq = req;
    selfTestPass = pass;
    rstN = 1'b1;
    if (abortAt >= 0) begin
      repeat (abortAt) @(negedge clk);
      rstN = 1'b0;
      #1;
      checkHeld("R11 abort");
      @(negedge clk);
      rstN = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    clkScale = ~scale;
    selfTestReq = ~req;
    chk("R1 flush off", {31'b0, pipeFlush}, 32'h0);
    repeat (total - 1) @(posedge clk);
    @(negedge clk);
    chk(req ? "R7 early" : "R5 early", {31'b0, fetchReq}, 32'h0);
    chk("R6 no bus yet", {31'b0, busEnable}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk(req ? "R7 on time" : "R5 on time", {31'b0, fetchReq}, 32'h1);
    chk("R9 addr", fetchAddr, 32'hFFFF_FFF0);
    chk("R8 acc", accInit, expAcc(req, pass));
    chk("R10 not yet run", {31'b0, execEnable}, 32'h0);
    for (int i = 0; i < ackDly; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9 held", {31'b0, fetchReq}, 32'h1);
    end
    fetchAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fetchAck = 1'b0;
    chk("R10 run", {29'b0, fetchReq, execEnable, busEnable}, {29'b0, 1'b0, 1'b1, 1'b1});
    chk("R10 flush", {31'b0, pipeFlush}, 32'h0);
    selfTestPass = ~pass;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 acc kept", accInit, expAcc(req, pass));
    chk("R10 stays", {31'b0, execEnable}, 32'h1);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 4; s++) runTrial(2'(s), 1'b0, 1'b0, 0, -1, 8'h5A);
    runTrial(2'd1, 1'b1, 1'b1, 1, -1, 8'hC3);
    runTrial(2'd2, 1'b1, 1'b0, 2, -1, 8'h00);
    runTrial(2'd3, 1'b0, 1'b0, 0, 40, 8'hFF);
    runTrial(2'd0, 1'b1, 1'b0, 0, 170, 8'h81);
    for (int t = 0; t < 12; t++) begin
      logic [1:0] sc;
      bit rq, ps;
      int ad, ab;
      sc = 2'($urandom_range(0, 3));
      rq = 1'($urandom_range(0, 1));
      ps = 1'($urandom_range(0, 1));
      ad = $urandom_range(0, 4);
      ab = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 200)) : -1;
      runTrial(sc, rq, ps, ad, ab, 8'($urandom));
    end
    finishRun();
  end

endmodule